// File: doc/BRIEF.md
# Series-Pack Cell Protection Controller

This block is the digital decision core of a protector for a lithium pack of two or three cells in series. Analog comparators digitise each cell voltage against five thresholds. They also digitise the current-sense pin against three overcurrent levels, a low-voltage level of about 0.8 V and the supply rail. An external delay timer sees the same raw flags and sends one-cycle expiry pulses. The controller qualifies each expiry pulse against the live flags, keeps one protection state, and drives three signals. The first releases the charge FET gate to high impedance. The second turns the discharge FET off. The third enables the internal pull-up on the sense pin.

Each protection state has its own release rule, and several of these rules read the sense pin. Overcharge can also clear as soon as discharge current appears. Overdischarge hysteresis is skipped when a charger lifts the sense pin to the supply. Power-down can be reached only through an overdischarge trip. A three-level control input can force both FETs off, run the block normally, or select a test mode. In test mode the external timer runs its short delays and overcurrent level 1 is ignored. A build option sets whether charging is allowed while a cell is near 0 V.

Top module: `bat_guard`

## Requirements
- R1: In the normal state, chg_rel_o, dsg_off_o and sense_pull_o are all 0. From reset the controller reaches normal when sense_low_i is 0 and every active cell is mid-range (not above overcharge detect, at or below overcharge release, not below overdischarge detect, at or above overdischarge release). This takes two clock edges: power-down, then overdischarge, then normal.
- R2: The overcharge state is entered when tmo_ovc_i pulses while some active cell has ovc_hi_i set. A pulse with no such cell has no effect. In overcharge, chg_rel_o=1 and dsg_off_o=0.
- R3: Overcharge returns to normal on either of two conditions. The first is that every active cell has ovc_rel_i set. The second is that no active cell has ovc_hi_i set while oc_i[0] is 1, which means discharge current is flowing.
- R4: The overdischarge state is entered when tmo_ovd_i pulses while some active cell has ovd_lo_i set. Here dsg_off_o=1 and chg_rel_o=0. The block moves on to power-down when sense_low_i is 1.
- R5: In power-down, chg_rel_o=1 and dsg_off_o=1. Power-down is left for overdischarge when sense_low_i is 0. It is entered only from overdischarge or from reset.
- R6: Overdischarge returns to normal with a rule that depends on sense_at_sup_i. With sense_at_sup_i=0, every active cell must have ovd_rel_i set. With sense_at_sup_i=1, it is enough that no active cell has ovd_lo_i set.
- R7: An overcurrent trip happens when tmo_oc_i[k] pulses while oc_i[k] is set, for any level k of 0..2. It sets chg_rel_o, dsg_off_o and sense_pull_o to 1. The state returns to normal once oc_i[0] is 0.
- R8: When ctl_i is 2 or 3 (inhibit), chg_rel_o=1, dsg_off_o=1 and sense_pull_o=0. The state is held, so no trip or release takes effect. ctl_i=0 selects normal operation.
- R9: When ctl_i is 1 (test), fast_o=1 and level-1 overcurrent trips are ignored. Levels 2 and 3 still trip. In any other mode fast_o=0.
- R10: Reset puts the block in power-down.
- R11: When several trips arrive in the same cycle, overcurrent wins over overdischarge, and overdischarge wins over overcharge.
- R12: With ZERO_CHG_OK=0, chg_rel_o is 1 whenever any active cell has zero_lo_i set, even in normal.
- R13: With N_CELLS=2, flags at bit 2 (the third cell) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovc_hi_i | input | 3 | Per cell: above overcharge detect |
| ovc_rel_i | input | 3 | Per cell: at or below overcharge release |
| ovd_lo_i | input | 3 | Per cell: below overdischarge detect |
| ovd_rel_i | input | 3 | Per cell: at or above overdischarge release |
| zero_lo_i | input | 3 | Per cell: below the 0 V charge-inhibit level |
| oc_i | input | 3 | Overcurrent levels 1..3 on bits 0..2 |
| sense_low_i | input | 1 | Sense pin below about 0.8 V |
| sense_at_sup_i | input | 1 | Sense pin at or above supply |
| ctl_i | input | 2 | 0 normal, 1 test, 2 or 3 inhibit |
| tmo_ovc_i | input | 1 | Overcharge delay expiry pulse |
| tmo_ovd_i | input | 1 | Overdischarge delay expiry pulse |
| tmo_oc_i | input | 3 | Overcurrent delay expiry pulses per level |
| chg_rel_o | output | 1 | 1 releases charge FET gate (high impedance) |
| dsg_off_o | output | 1 | 1 turns discharge FET off |
| sense_pull_o | output | 1 | 1 enables sense-pin pull-up |
| fast_o | output | 1 | Test mode: timer uses short delays |

## Verification
The outputs are decoded directly from the state register, so a wrong state shows at the ports on the edge after the faulty transition. A wrong power-down or overdischarge entry appears as an incorrect chg_rel_o. A missed or spurious overcurrent trip appears on sense_pull_o. Some release faults show only under particular flag mixes. Examples are overcharge clearing at detect without current, and overdischarge ignoring the charger bypass. For these, the bench holds each borderline pattern for at least one cycle and samples the outputs after it.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int MAX_CELLS = 3;
    localparam int OC_LEVELS = 3;

    typedef enum logic [2:0] {
        ST_PDN  = 3'd0,
        ST_NORM = 3'd1,
        ST_OVC  = 3'd2,
        ST_OVD  = 3'd3,
        ST_OC   = 3'd4
    } bp_state_e;

    typedef enum logic [1:0] {
        CTL_RUN  = 2'd0,
        CTL_TEST = 2'd1,
        CTL_INH  = 2'd2,
        CTL_OPEN = 2'd3
    } bp_ctl_e;

    typedef struct packed {
        logic any_ovc;
        logic all_crel;
        logic none_ovc;
        logic any_ovd;
        logic all_drel;
        logic any_zero;
    } cell_sum_t;

    function automatic logic is_inhibit(input logic [1:0] c);
        return c[1];
    endfunction
endpackage

// File: rtl/bp_cell_reduce.sv
module bp_cell_reduce
    import bp_pkg::*;
#(
    parameter int N_CELLS = 3
) (
    input  logic [MAX_CELLS-1:0] ovc_hi,
    input  logic [MAX_CELLS-1:0] ovc_rel,
    input  logic [MAX_CELLS-1:0] ovd_lo,
    input  logic [MAX_CELLS-1:0] ovd_rel,
    input  logic [MAX_CELLS-1:0] zero_lo,
    output cell_sum_t            sum
);
    logic [MAX_CELLS-1:0] hi_m, crel_m, lo_m, drel_m, zero_m;

    for (genvar i = 0; i < MAX_CELLS; i++) begin : g_cell
        if (i < N_CELLS) begin : g_used
            assign hi_m[i]   = ovc_hi[i];
            assign crel_m[i] = ovc_rel[i];
            assign lo_m[i]   = ovd_lo[i];
            assign drel_m[i] = ovd_rel[i];
            assign zero_m[i] = zero_lo[i];
        end else begin : g_unused
            assign hi_m[i]   = 1'b0;
            assign crel_m[i] = 1'b1;
            assign lo_m[i]   = 1'b0;
            assign drel_m[i] = 1'b1;
            assign zero_m[i] = 1'b0;
        end
    end

    always_comb begin
        sum.any_ovc  = |hi_m;
        sum.none_ovc = ~(|hi_m);
        sum.all_crel = &crel_m;
        sum.any_ovd  = |lo_m;
        sum.all_drel = &drel_m;
        sum.any_zero = |zero_m;
    end
endmodule

// File: rtl/bp_fsm.sv
module bp_fsm
    import bp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cell_sum_t            sum,
    input  logic [OC_LEVELS-1:0] oc,
    input  logic                 sense_low,
    input  logic                 sense_at_sup,
    input  logic [1:0]           ctl,
    input  logic                 tmo_ovc,
    input  logic                 tmo_ovd,
    input  logic [OC_LEVELS-1:0] tmo_oc,
    output bp_state_e            state
);
    bp_state_e state_q, state_d;
    logic [OC_LEVELS-1:0] oc_en;
    logic oc_trip, ovd_trip, ovc_trip, inh;

    assign inh      = is_inhibit(ctl);
    assign oc_en    = {{(OC_LEVELS-1){1'b1}}, (ctl != CTL_TEST)};
    assign oc_trip  = |(oc & tmo_oc & oc_en);
    assign ovd_trip = sum.any_ovd & tmo_ovd;
    assign ovc_trip = sum.any_ovc & tmo_ovc;

    always_comb begin
        state_d = state_q;
        if (!inh) begin
            unique case (state_q)
                ST_NORM: begin
                    if (oc_trip)       state_d = ST_OC;
                    else if (ovd_trip) state_d = ST_OVD;
                    else if (ovc_trip) state_d = ST_OVC;
                end
                ST_OVC: begin
                    if (oc_trip)       state_d = ST_OC;
                    else if (ovd_trip) state_d = ST_OVD;
                    else if (sum.all_crel || (sum.none_ovc && oc[0]))
                        state_d = ST_NORM;
                end
                ST_OVD: begin
                    if (sense_low) state_d = ST_PDN;
                    else if (sense_at_sup ? !sum.any_ovd : sum.all_drel)
                        state_d = ST_NORM;
                end
                ST_PDN: begin
                    if (!sense_low) state_d = ST_OVD;
                end
                ST_OC: begin
                    if (!oc[0]) state_d = ST_NORM;
                end
                default: state_d = ST_PDN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PDN;
        else     state_q <= state_d;
    end

    assign state = state_q;

    // R2: overcharge entered from normal only after a qualified expiry
    a_r2_ovc_qualified: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OVC && $past(state_q) == ST_NORM)
            |-> $past(tmo_ovc && sum.any_ovc));
    // R5: power-down entered only from overdischarge
    a_r5_pdn_entry: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PDN && $past(state_q) != ST_PDN)
            |-> $past(state_q) == ST_OVD);
    // R6: without a charger, overdischarge releases only with all cells released
    a_r6_ovd_hyst: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NORM && $past(state_q) == ST_OVD && !$past(sense_at_sup))
            |-> $past(sum.all_drel));
    // R8: inhibit freezes the state
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        inh |=> state_q == $past(state_q));
    // R9: test mode suppresses level-1-only trips
    a_r9_no_lvl1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NORM && ctl == CTL_TEST && oc[2:1] == 2'b00)
            |=> state_q != ST_OC);
endmodule

// File: rtl/bp_out_drive.sv
module bp_out_drive
    import bp_pkg::*;
#(
    parameter bit ZERO_CHG_OK = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  bp_state_e state,
    input  logic [1:0] ctl,
    input  logic      any_zero,
    output logic      chg_rel,
    output logic      dsg_off,
    output logic      sense_pull,
    output logic      fast
);
    logic st_chg, st_dsg, st_pull, zero_blk, inh;

    assign inh = is_inhibit(ctl);

    always_comb begin
        st_chg  = 1'b0;
        st_dsg  = 1'b0;
        st_pull = 1'b0;
        unique case (state)
            ST_OVC:  st_chg = 1'b1;
            ST_OVD:  st_dsg = 1'b1;
            ST_PDN:  begin st_chg = 1'b1; st_dsg = 1'b1; end
            ST_OC:   begin st_chg = 1'b1; st_dsg = 1'b1; st_pull = 1'b1; end
            default: ;
        endcase
    end

    assign zero_blk   = !ZERO_CHG_OK && any_zero;
    assign chg_rel    = inh | st_chg | zero_blk;
    assign dsg_off    = inh | st_dsg;
    assign sense_pull = !inh && st_pull;
    assign fast       = (ctl == CTL_TEST);

    // R7: pull-up only ever accompanies both FETs off
    a_r7_pull_both_off: assert property (@(posedge clk) disable iff (rst)
        sense_pull |-> (chg_rel && dsg_off));
    // R1: in normal with no inhibit or zero-volt cell, both FETs enabled
    a_r1_norm_on: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORM && !ctl[1] && !any_zero) |-> (!chg_rel && !dsg_off));
endmodule

// File: rtl/bat_guard.sv
module bat_guard
    import bp_pkg::*;
#(
    parameter int N_CELLS     = 3,
    parameter bit ZERO_CHG_OK = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] ovc_hi_i,
    input  logic [2:0] ovc_rel_i,
    input  logic [2:0] ovd_lo_i,
    input  logic [2:0] ovd_rel_i,
    input  logic [2:0] zero_lo_i,
    input  logic [2:0] oc_i,
    input  logic       sense_low_i,
    input  logic       sense_at_sup_i,
    input  logic [1:0] ctl_i,
    input  logic       tmo_ovc_i,
    input  logic       tmo_ovd_i,
    input  logic [2:0] tmo_oc_i,
    output logic       chg_rel_o,
    output logic       dsg_off_o,
    output logic       sense_pull_o,
    output logic       fast_o
);
    cell_sum_t sum;
    bp_state_e state;

    initial begin
        assert (N_CELLS == 2 || N_CELLS == 3)
            else $error("N_CELLS must be 2 or 3");
    end

    bp_cell_reduce #(.N_CELLS(N_CELLS)) u_reduce (
        .ovc_hi  (ovc_hi_i),
        .ovc_rel (ovc_rel_i),
        .ovd_lo  (ovd_lo_i),
        .ovd_rel (ovd_rel_i),
        .zero_lo (zero_lo_i),
        .sum     (sum)
    );

    bp_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sum          (sum),
        .oc           (oc_i),
        .sense_low    (sense_low_i),
        .sense_at_sup (sense_at_sup_i),
        .ctl          (ctl_i),
        .tmo_ovc      (tmo_ovc_i),
        .tmo_ovd      (tmo_ovd_i),
        .tmo_oc       (tmo_oc_i),
        .state        (state)
    );

    bp_out_drive #(.ZERO_CHG_OK(ZERO_CHG_OK)) u_out (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .ctl        (ctl_i),
        .any_zero   (sum.any_zero),
        .chg_rel    (chg_rel_o),
        .dsg_off    (dsg_off_o),
        .sense_pull (sense_pull_o),
        .fast       (fast_o)
    );
endmodule

// File: tb/bat_guard_tb.sv
module bat_guard_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] ovc_hi, ovc_rel, ovd_lo, ovd_rel, zero_lo;
    logic [2:0] oc = 3'b000, tmo_oc = 3'b000;
    logic sense_low = 1'b1, sense_at_sup = 1'b0;
    logic [1:0] ctl = 2'd0;
    logic tmo_ovc = 1'b0, tmo_ovd = 1'b0;
    logic chg, dsg, pull, fast;
    logic chg2, dsg2, pull2, fast2;
    int checks = 0;
    int errors = 0;
    int lvl [3] = '{3, 3, 3};

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 3; i++) begin
            zero_lo[i] = (lvl[i] == 0);
            ovd_lo[i]  = (lvl[i] <= 1);
            ovd_rel[i] = (lvl[i] >= 3);
            ovc_rel[i] = (lvl[i] <= 3);
            ovc_hi[i]  = (lvl[i] == 5);
        end
    end

    bat_guard u_dut (
        .clk(clk), .rst(rst), .ovc_hi_i(ovc_hi), .ovc_rel_i(ovc_rel),
        .ovd_lo_i(ovd_lo), .ovd_rel_i(ovd_rel), .zero_lo_i(zero_lo),
        .oc_i(oc), .sense_low_i(sense_low), .sense_at_sup_i(sense_at_sup),
        .ctl_i(ctl), .tmo_ovc_i(tmo_ovc), .tmo_ovd_i(tmo_ovd), .tmo_oc_i(tmo_oc),
        .chg_rel_o(chg), .dsg_off_o(dsg), .sense_pull_o(pull), .fast_o(fast));

    bat_guard #(.N_CELLS(2)) u_dut2 (
        .clk(clk), .rst(rst), .ovc_hi_i(ovc_hi), .ovc_rel_i(ovc_rel),
        .ovd_lo_i(ovd_lo), .ovd_rel_i(ovd_rel), .zero_lo_i(zero_lo),
        .oc_i(oc), .sense_low_i(sense_low), .sense_at_sup_i(sense_at_sup),
        .ctl_i(ctl), .tmo_ovc_i(tmo_ovc), .tmo_ovd_i(tmo_ovd), .tmo_oc_i(tmo_oc),
        .chg_rel_o(chg2), .dsg_off_o(dsg2), .sense_pull_o(pull2), .fast_o(fast2));

    task automatic expect3(string tag, logic ec, logic ed, logic ep);
        checks++;
        if ({chg, dsg, pull} !== {ec, ed, ep}) begin
            errors++;
            $display("FAIL %s: chg/dsg/pull actual %b%b%b expected %b%b%b",
                     tag, chg, dsg, pull, ec, ed, ep);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ovc();
        tmo_ovc = 1'b1; step(); tmo_ovc = 1'b0;
    endtask
    task automatic pulse_ovd();
        tmo_ovd = 1'b1; step(); tmo_ovd = 1'b0;
    endtask
    task automatic pulse_oc(logic [2:0] m);
        tmo_oc = m; step(); tmo_oc = 3'b000;
    endtask

    task automatic t_reset();
        step(); expect3("R10 reset power-down", 1, 1, 0);
        rst = 1'b0; step(); expect3("R10 held power-down", 1, 1, 0);
        sense_low = 1'b0; step(); expect3("R5 power-down to overdischarge", 0, 1, 0);
        step(); expect3("R1 reach normal", 0, 0, 0);
    endtask

    task automatic t_overcharge();
        pulse_ovc(); expect3("R2 pulse with no high cell ignored", 0, 0, 0);
        lvl[1] = 5; step(); expect3("R2 no trip before expiry", 0, 0, 0);
        pulse_ovc(); expect3("R2 overcharge entered", 1, 0, 0);
        lvl[1] = 4; step(); expect3("R3 stays between release and detect", 1, 0, 0);
        oc[0] = 1'b1; step(); expect3("R3 release by discharge current", 0, 0, 0);
        oc[0] = 1'b0; lvl[1] = 5; pulse_ovc(); expect3("R2 re-enter overcharge", 1, 0, 0);
        lvl[1] = 3; step(); expect3("R3 release at release level", 0, 0, 0);
    endtask

    task automatic t_overdischarge();
        lvl[0] = 1; pulse_ovd(); expect3("R4 overdischarge entered", 0, 1, 0);
        sense_low = 1'b1; step(); expect3("R4 to power-down", 1, 1, 0);
        step(); expect3("R5 power-down holds", 1, 1, 0);
        sense_low = 1'b0; lvl[0] = 2; step(); expect3("R5 wake to overdischarge", 0, 1, 0);
        step(); expect3("R6 no charger needs release level", 0, 1, 0);
        sense_at_sup = 1'b1; step(); expect3("R6 charger bypasses hysteresis", 0, 0, 0);
        sense_at_sup = 1'b0; lvl[0] = 1; pulse_ovd(); expect3("R4 second trip", 0, 1, 0);
        lvl[0] = 3; step(); expect3("R6 release at release level", 0, 0, 0);
    endtask

    task automatic t_overcurrent();
        oc = 3'b011; pulse_oc(3'b010); expect3("R7 level-2 trip", 1, 1, 1);
        oc = 3'b001; step(); expect3("R7 held while level-1 flagged", 1, 1, 1);
        oc = 3'b000; step(); expect3("R7 clear to normal", 0, 0, 0);
        oc = 3'b111; pulse_oc(3'b100); expect3("R7 level-3 trip", 1, 1, 1);
        oc = 3'b000; step(); expect3("R7 clear after level 3", 0, 0, 0);
        oc = 3'b001; pulse_oc(3'b001); expect3("R7 level-1 trip in run mode", 1, 1, 1);
        oc = 3'b000; step(); expect3("R7 clear after level 1", 0, 0, 0);
    endtask

    task automatic t_control();
        ctl = 2'd2; step(); expect3("R8 inhibit forces off", 1, 1, 0);
        lvl[0] = 5; pulse_ovc(); lvl[0] = 4;
        ctl = 2'd3; step(); expect3("R8 open level inhibits", 1, 1, 0);
        ctl = 2'd0; step(); expect3("R8 trip during inhibit had no effect", 0, 0, 0);
        lvl[0] = 3;
        ctl = 2'd1; step();
        checks++;
        if (fast !== 1'b1) begin errors++; $display("FAIL R9 fast actual %b expected 1", fast); end
        oc = 3'b001; pulse_oc(3'b001); expect3("R9 level-1 ignored in test", 0, 0, 0);
        oc = 3'b101; pulse_oc(3'b100); expect3("R9 level-3 trips in test", 1, 1, 1);
        oc = 3'b000; ctl = 2'd0; step(); expect3("R9 clear", 0, 0, 0);
        checks++;
        if (fast !== 1'b0) begin errors++; $display("FAIL R9 fast actual %b expected 0", fast); end
    endtask

    task automatic t_priority();
        lvl[0] = 5; lvl[1] = 1; oc = 3'b010;
        tmo_ovc = 1'b1; tmo_ovd = 1'b1; tmo_oc = 3'b010; step();
        tmo_ovc = 1'b0; tmo_ovd = 1'b0; tmo_oc = 3'b000;
        expect3("R11 overcurrent wins", 1, 1, 1);
        oc = 3'b000; lvl[0] = 3; lvl[1] = 3; step(); expect3("R11 back to normal", 0, 0, 0);
        lvl[0] = 5; lvl[1] = 1;
        tmo_ovc = 1'b1; tmo_ovd = 1'b1; step();
        tmo_ovc = 1'b0; tmo_ovd = 1'b0;
        expect3("R11 overdischarge beats overcharge", 0, 1, 0);
        lvl[0] = 3; lvl[1] = 3; step(); expect3("R11 release", 0, 0, 0);
    endtask

    task automatic t_zero();
        lvl[1] = 0; step(); expect3("R12 zero-volt cell blocks charge", 1, 0, 0);
        lvl[1] = 3; step(); expect3("R12 charge restored", 0, 0, 0);
    endtask

    task automatic t_two_cell();
        lvl[2] = 5; pulse_ovc();
        expect3("R13 three-cell build trips on cell 3", 1, 0, 0);
        checks++;
        if ({chg2, dsg2, pull2} !== 3'b000) begin
            errors++;
            $display("FAIL R13 two-cell outputs actual %b%b%b expected 000", chg2, dsg2, pull2);
        end
        lvl[2] = 0; step();
        checks++;
        if (chg2 !== 1'b0) begin
            errors++;
            $display("FAIL R13 two-cell ignores cell 3 zero flag actual %b expected 0", chg2);
        end
        lvl[2] = 3; step(); expect3("R13 release", 0, 0, 0);
    endtask

    initial begin
        step(3);
        t_reset();
        t_overcharge();
        t_overdischarge();
        t_overcurrent();
        t_control();
        t_priority();
        t_zero();
        t_two_cell();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule